// File: doc/BRIEF.md
# Strobe-Handshake Coprocessor Register Port

This block sits between a host processor's asynchronous, strobe-based bus and a small bank of coprocessor interface registers. The host marks each cycle with an active-low address strobe. Chip select and the read/write line are already stable when that strobe asserts. On a write, a separate active-low data strobe says when the write data is valid. The block brings these strobes into its own clock domain, sequences the cycle and decodes the target register. It then answers on two active-low, three-state acknowledge lines. The pattern of those lines tells the host both that the cycle is complete and how wide the responding port is.

The register bank holds eight 16-bit registers and four 32-bit registers. Address bit 4 chooses the class. The 16-bit registers are always wired to the upper half of the data bus. When the configured port is 32 bits wide, an access to a 16-bit register is therefore acknowledged as a 16-bit port, so the host takes the data from the upper lanes whatever the word address. A static width input sets the port to 8, 16 or 32 bits. In the narrower modes the block moves the addressed word or byte of a register onto the upper lanes.

Top module: `cop_bus_slave`

## Requirements
- R1: After reset both acknowledge lines and the data bus are released (ack_oe_o=0, data_oe_o=0, ack_n_o=2'b11), and every register reads back as zero.
- R2: A strobe cycle with cs_n_i high gets no acknowledge at any point.
- R3: A write cycle is not acknowledged while ds_n_i stays high. The register is updated from data_i only once ds_n_i is low.
- R4: The acknowledge code ack_n_o = {line1, line0} depends on the width setting. With width_cfg_i=2'b00 (8-bit) it is 2'b10. With 2'b01 (16-bit) it is 2'b01. With 2'b10 or 2'b11 (32-bit) it is 2'b00 when addr_i[4]=1 and 2'b01 when addr_i[4]=0.
- R5: On a read, data_oe_o asserts exactly one clock after the acknowledge first asserts. data_o then stays stable until the acknowledge ends.
- R6: The acknowledge stays asserted while as_n_i is low. After as_n_i rises, both lines are driven high for exactly one clock and then float.
- R7: data_oe_o is never asserted outside a read cycle.
- R8: In 32-bit mode a 32-bit register moves on all 32 lanes. A 16-bit register moves on data[31:16]; it reads with data[15:0]=0, and a write to it ignores data[15:0].
- R9: In 16-bit mode every transfer uses data[31:16] (lower lanes read as 0). For a 32-bit register, addr_i[1]=0 selects bits 31:16 and addr_i[1]=1 selects bits 15:0.
- R10: In 8-bit mode every transfer uses data[31:24] (other lanes read as 0). For a 32-bit register, addr_i[1:0]=0 selects bits 31:24, up to 3 for bits 7:0. For a 16-bit register, addr_i[0]=0 selects bits 15:8.
- R11: addr_i[3:1] indexes the 16-bit registers and addr_i[3:2] indexes the 32-bit registers. A write changes only the addressed bits of the addressed register.
- R12: If as_n_i rises during a write before ds_n_i asserts, the cycle ends with no acknowledge and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n_i | input | 1 | Address strobe, active low |
| cs_n_i | input | 1 | Chip select, active low |
| rw_i | input | 1 | 1 = host reads, 0 = host writes |
| ds_n_i | input | 1 | Write data strobe, active low |
| addr_i | input | 5 | Register address; bit 4 = 32-bit class |
| data_i | input | 32 | Write data from host |
| width_cfg_i | input | 2 | Port width: 00 = 8, 01 = 16, 1x = 32 |
| data_o | output | 32 | Read data to host |
| data_oe_o | output | 1 | Drive enable for data_o |
| ack_n_o | output | 2 | Acknowledge lines {line1, line0}, active low |
| ack_oe_o | output | 1 | Drive enable for ack_n_o |

## Verification
Random cycles mix all four width settings, both register classes, every byte and word offset, and both directions. Each read is compared against a bench model of the registers. This separates a wrong lane choice from a wrong register index, and a merge that disturbs neighbouring bits from one that does not. Directed cycles cover several cases: a strobe with chip select high, which shows whether chip select is sampled; a write abandoned before the data strobe, which shows whether commit waits for the strobe; and a hold of the address strobe, which shows whether the acknowledge tracks it. The order of acknowledge and read-data enable is checked on every read.

// File: rtl/cop_bus_pkg.sv
`timescale 1ns/1ps
package cop_bus_pkg;

   typedef enum logic [1:0] {
      PW_8    = 2'b00,
      PW_16   = 2'b01,
      PW_32   = 2'b10,
      PW_32_A = 2'b11
   } port_w_t;

   typedef enum logic [1:0] {
      CY_IDLE,
      CY_DECODE,
      CY_ACK,
      CY_RELEASE
   } cyc_state_t;

   // {line1, line0}, active low
   function automatic logic [1:0] ack_code(port_w_t pw, logic cls32);
      case (pw)
         PW_8:    ack_code = 2'b10;
         PW_16:   ack_code = 2'b01;
         default: ack_code = cls32 ? 2'b00 : 2'b01;
      endcase
   endfunction

endpackage

// File: rtl/cop_sync.sv
`timescale 1ns/1ps
module cop_sync #(
   parameter int          WIDTH     = 3,
   parameter int          STAGES    = 2,
   parameter logic [31:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   localparam logic [WIDTH-1:0] RV = RESET_VAL[WIDTH-1:0];

   if (STAGES < 2) begin : g_bad_stages
      $error("cop_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[s] <= RV;
         else if (s == 0)
            stage_q[s] <= d_i;
         else
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cop_cycle_fsm.sv
`timescale 1ns/1ps
module cop_cycle_fsm
   import cop_bus_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic as_n_s,
   input  logic cs_n_s,
   input  logic ds_n_s,
   input  logic rw_q,
   output logic cap_en,
   output logic wr_commit,
   output logic rd_load,
   output logic ack_on,
   output logic ack_drive,
   output logic data_en
);
   cyc_state_t state_q, state_d;
   logic       dvalid_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         CY_IDLE:    if (!as_n_s && !cs_n_s) state_d = CY_DECODE;
         CY_DECODE: begin
            if (as_n_s)              state_d = CY_IDLE;
            else if (rw_q || !ds_n_s) state_d = CY_ACK;
         end
         CY_ACK:     if (as_n_s) state_d = CY_RELEASE;
         CY_RELEASE: state_d = CY_IDLE;
         default:    state_d = CY_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= CY_IDLE;
         dvalid_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         dvalid_q <= (state_q == CY_ACK) && (state_d == CY_ACK);
      end
   end

   assign cap_en    = (state_q == CY_IDLE) && (state_d == CY_DECODE);
   assign wr_commit = (state_q == CY_DECODE) && !as_n_s && !rw_q && !ds_n_s;
   assign rd_load   = (state_q == CY_DECODE) && !as_n_s && rw_q;
   assign ack_on    = (state_q == CY_ACK);
   assign ack_drive = (state_q == CY_ACK) || (state_q == CY_RELEASE);
   assign data_en   = (state_q == CY_ACK) && dvalid_q && rw_q;
endmodule

// File: rtl/cop_regfile.sv
`timescale 1ns/1ps
module cop_regfile
   import cop_bus_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  port_w_t           pw,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int HALF_W = DATA_W / 2;
   localparam int CLS    = ADDR_W - 1;
   localparam int IDX16W = ADDR_W - 2;
   localparam int IDX32W = ADDR_W - 3;
   localparam int N16    = 1 << IDX16W;
   localparam int N32    = 1 << IDX32W;

   logic [HALF_W-1:0] r16 [N16];
   logic [DATA_W-1:0] r32 [N32];

   logic [IDX16W-1:0] idx16;
   logic [IDX32W-1:0] idx32;
   logic [1:0]        boff;
   logic              cls32;
   logic [HALF_W-1:0] cur16, nxt16;
   logic [DATA_W-1:0] cur32, nxt32;
   logic [7:0]        wbyte;
   logic [HALF_W-1:0] whalf;

   assign cls32 = addr[CLS];
   assign idx16 = addr[CLS-1:1];
   assign idx32 = addr[CLS-1:2];
   assign boff  = addr[1:0];
   assign cur16 = r16[idx16];
   assign cur32 = r32[idx32];
   assign wbyte = wdata[DATA_W-1 -: 8];
   assign whalf = wdata[DATA_W-1 -: HALF_W];

   // Lane routing toward the host
   always_comb begin
      rdata = '0;
      case (pw)
         PW_8: begin
            if (cls32) rdata[DATA_W-1 -: 8] = cur32[8*(3-boff) +: 8];
            else       rdata[DATA_W-1 -: 8] = cur16[8*(1-boff[0]) +: 8];
         end
         PW_16: begin
            if (cls32) rdata[DATA_W-1 -: HALF_W] = cur32[HALF_W*(1-boff[1]) +: HALF_W];
            else       rdata[DATA_W-1 -: HALF_W] = cur16;
         end
         default: begin
            if (cls32) rdata = cur32;
            else       rdata[DATA_W-1 -: HALF_W] = cur16;
         end
      endcase
   end

   // Merge of incoming lanes into the addressed register
   always_comb begin
      nxt16 = cur16;
      nxt32 = cur32;
      case (pw)
         PW_8: begin
            nxt16[8*(1-boff[0]) +: 8] = wbyte;
            nxt32[8*(3-boff) +: 8]    = wbyte;
         end
         PW_16: begin
            nxt16                               = whalf;
            nxt32[HALF_W*(1-boff[1]) +: HALF_W] = whalf;
         end
         default: begin
            nxt16 = whalf;
            nxt32 = wdata;
         end
      endcase
   end

   for (genvar g = 0; g < N16; g++) begin : g_r16
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r16[g] <= '0;
         else if (wr_en && !cls32 && (idx16 == IDX16W'(g)))
            r16[g] <= nxt16;
      end
   end

   for (genvar g = 0; g < N32; g++) begin : g_r32
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r32[g] <= '0;
         else if (wr_en && cls32 && (idx32 == IDX32W'(g)))
            r32[g] <= nxt32;
      end
   end
endmodule

// File: rtl/cop_bus_slave.sv
`timescale 1ns/1ps
module cop_bus_slave
   import cop_bus_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_n_i,
   input  logic              cs_n_i,
   input  logic              rw_i,
   input  logic              ds_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [1:0]        width_cfg_i,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe_o,
   output logic [1:0]        ack_n_o,
   output logic              ack_oe_o
);
   if (DATA_W != 32) begin : g_bad_data_w
      $error("cop_bus_slave: DATA_W must be 32");
   end
   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr_w
      $error("cop_bus_slave: ADDR_W must lie in 5..8");
   end

   localparam int CLS = ADDR_W - 1;

   logic [2:0]        strb_s;
   logic              as_n_s, cs_n_s, ds_n_s;
   logic              cap_en, wr_commit, rd_load, ack_on, ack_drive, data_en;
   logic [ADDR_W-1:0] addr_q;
   logic              rw_q;
   logic [DATA_W-1:0] rd_word, rd_q;
   port_w_t           pw;

   assign pw = port_w_t'(width_cfg_i);

   cop_sync #(
      .WIDTH     (3),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL ('1)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({as_n_i, cs_n_i, ds_n_i}),
      .q_o   (strb_s)
   );
   assign {as_n_s, cs_n_s, ds_n_s} = strb_s;

   cop_cycle_fsm i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .as_n_s    (as_n_s),
      .cs_n_s    (cs_n_s),
      .ds_n_s    (ds_n_s),
      .rw_q      (rw_q),
      .cap_en    (cap_en),
      .wr_commit (wr_commit),
      .rd_load   (rd_load),
      .ack_on    (ack_on),
      .ack_drive (ack_drive),
      .data_en   (data_en)
   );

   // Address and direction are stable once the strobe is seen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         rw_q   <= 1'b1;
      end else if (cap_en) begin
         addr_q <= addr_i;
         rw_q   <= rw_i;
      end
   end

   cop_regfile #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .pw    (pw),
      .addr  (addr_q),
      .wr_en (wr_commit),
      .wdata (data_i),
      .rdata (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_load) rd_q <= rd_word;
   end

   assign data_o    = rd_q;
   assign data_oe_o = data_en;
   assign ack_oe_o  = ack_drive;
   assign ack_n_o   = ack_on ? ack_code(pw, addr_q[CLS]) : 2'b11;
endmodule

// File: rtl/cop_bus_slave_chk.sv
`timescale 1ns/1ps
module cop_bus_slave_chk #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              as_n_i,
   input logic              cs_n_i,
   input logic              rw_i,
   input logic              ds_n_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [1:0]        width_cfg_i,
   input logic [DATA_W-1:0] data_o,
   input logic              data_oe_o,
   input logic [1:0]        ack_n_o,
   input logic              ack_oe_o
);
   logic       ack_on;
   logic [1:0] exp_code;

   assign ack_on   = ack_oe_o && (ack_n_o != 2'b11);
   assign exp_code = (width_cfg_i == 2'b00) ? 2'b10 :
                     (width_cfg_i == 2'b01) ? 2'b01 :
                     (addr_i[ADDR_W-1] ? 2'b00 : 2'b01);

   p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_oe_o |-> (ack_n_o == 2'b11) && !data_oe_o);

   p_cs_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_on) |-> !cs_n_i);

   p_wr_after_ds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ack_on) && !rw_i) |-> !ds_n_i);

   p_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_on |-> (ack_n_o == exp_code));

   p_data_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_oe_o) |-> ($past(ack_on) && ack_on));

   p_data_in_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_o |-> ack_on);

   p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));

   p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_on) |-> $past(as_n_i, 2));

   p_release_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_oe_o && !ack_on) |=> !ack_oe_o);

   p_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_o |-> rw_i);
endmodule

bind cop_bus_slave cop_bus_slave_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) i_cop_bus_slave_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .as_n_i      (as_n_i),
   .cs_n_i      (cs_n_i),
   .rw_i        (rw_i),
   .ds_n_i      (ds_n_i),
   .addr_i      (addr_i),
   .width_cfg_i (width_cfg_i),
   .data_o      (data_o),
   .data_oe_o   (data_oe_o),
   .ack_n_o     (ack_n_o),
   .ack_oe_o    (ack_oe_o)
);

// File: tb/test_cop_bus_slave.sv
`timescale 1ns/1ps
module test_cop_bus_slave;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        as_n_i = 1'b1, cs_n_i = 1'b1, rw_i = 1'b1, ds_n_i = 1'b1;
   logic [4:0]  addr_i = '0;
   logic [31:0] data_i = '0;
   logic [1:0]  width_cfg_i = 2'b10;
   logic [31:0] data_o;
   logic        data_oe_o;
   logic [1:0]  ack_n_o;
   logic        ack_oe_o;

   int n_cmp = 0;
   int n_err = 0;
   bit done  = 1'b0;

   logic [15:0] m16 [8];
   logic [31:0] m32 [4];

   always #2.5 clk = ~clk;

   cop_bus_slave i_cop_bus_slave (
      .clk (clk), .rst_n (rst_n), .as_n_i (as_n_i), .cs_n_i (cs_n_i),
      .rw_i (rw_i), .ds_n_i (ds_n_i), .addr_i (addr_i), .data_i (data_i),
      .width_cfg_i (width_cfg_i), .data_o (data_o), .data_oe_o (data_oe_o),
      .ack_n_o (ack_n_o), .ack_oe_o (ack_oe_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_ack(input logic [1:0] w, input logic [4:0] a);
      if (w == 2'b00)      return 2'b10;
      else if (w == 2'b01) return 2'b01;
      else                 return a[4] ? 2'b00 : 2'b01;
   endfunction

   function automatic logic [31:0] exp_read(input logic [1:0] w, input logic [4:0] a);
      logic [31:0] v32 = m32[a[3:2]];
      logic [15:0] v16 = m16[a[3:1]];
      logic [7:0]  b;
      if (w[1]) return a[4] ? v32 : {v16, 16'h0};
      if (w == 2'b01) begin
         if (!a[4]) return {v16, 16'h0};
         return a[1] ? {v32[15:0], 16'h0} : {v32[31:16], 16'h0};
      end
      if (a[4]) b = 8'(v32 >> (8 * (3 - int'(a[1:0]))));
      else      b = a[0] ? v16[7:0] : v16[15:8];
      return {b, 24'h0};
   endfunction

   task automatic model_write(input logic [1:0] w, input logic [4:0] a, input logic [31:0] d);
      int sh;
      if (a[4]) begin
         if (w[1]) m32[a[3:2]] = d;
         else if (w == 2'b01) begin
            if (a[1]) m32[a[3:2]][15:0]  = d[31:16];
            else      m32[a[3:2]][31:16] = d[31:16];
         end else begin
            sh = 8 * (3 - int'(a[1:0]));
            m32[a[3:2]] = (m32[a[3:2]] & ~(32'hFF << sh)) | (32'(d[31:24]) << sh);
         end
      end else begin
         if (w != 2'b00)  m16[a[3:1]] = d[31:16];
         else if (a[0])   m16[a[3:1]][7:0]  = d[31:24];
         else             m16[a[3:1]][15:8] = d[31:24];
      end
   endtask

   // One complete host cycle; hold adds idle clocks with the strobe held low
   task automatic bus_cycle(input logic rw, input logic [1:0] w, input logic [4:0] a,
                            input logic [31:0] d, input int hold);
      bit seen = 1'b0;
      @(negedge clk);
      width_cfg_i = w; addr_i = a; rw_i = rw; cs_n_i = 1'b0;
      data_i = rw ? 32'h0 : d; as_n_i = 1'b0;
      if (!rw) begin
         repeat (6) @(negedge clk);
         check(ack_oe_o == 1'b0, "R3 no ack before data strobe", 32'(ack_oe_o), 32'h0);
         ds_n_i = 1'b0;
      end
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (ack_oe_o && ack_n_o != 2'b11) begin seen = 1'b1; break; end
      end
      check(seen, "R6 ack arrives", 32'(seen), 32'h1);
      check(ack_n_o == exp_ack(w, a), "R4 ack width code", 32'(ack_n_o), 32'(exp_ack(w, a)));
      if (rw) begin
         check(data_oe_o == 1'b0, "R5 data enable after ack", 32'(data_oe_o), 32'h0);
         @(negedge clk);
         check(data_oe_o == 1'b1, "R5 data enable one clock later", 32'(data_oe_o), 32'h1);
         check(data_o == exp_read(w, a), "R8 R9 R10 R11 read data", data_o, exp_read(w, a));
      end else begin
         model_write(w, a, d);
         @(negedge clk);
         check(data_oe_o == 1'b0, "R7 no data drive on write", 32'(data_oe_o), 32'h0);
      end
      repeat (hold) @(negedge clk);
      if (hold > 0)
         check(ack_oe_o && ack_n_o == exp_ack(w, a), "R6 ack held while strobe low",
               32'(ack_n_o), 32'(exp_ack(w, a)));
      as_n_i = 1'b1; ds_n_i = 1'b1; cs_n_i = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (!(ack_oe_o && ack_n_o != 2'b11)) break;
      end
      check(ack_oe_o && ack_n_o == 2'b11, "R6 lines driven high", {ack_oe_o, 29'h0, ack_n_o}, 32'h8000_0003);
      @(negedge clk);
      check(!ack_oe_o && !data_oe_o, "R6 lines float", 32'(ack_oe_o), 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   end

   initial begin
      bit          any_ack;
      logic [31:0] seed_dummy;
      seed_dummy = $urandom(32'd1357);
      for (int i = 0; i < 8; i++) m16[i] = '0;
      for (int i = 0; i < 4; i++) m32[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!ack_oe_o && !data_oe_o && ack_n_o == 2'b11, "R1 idle after reset",
            {ack_oe_o, data_oe_o, 28'h0, ack_n_o}, 32'h3);
      for (int r = 0; r < 8; r++) bus_cycle(1'b1, 2'b10, 5'(r << 1), 32'h0, 0);
      for (int r = 0; r < 4; r++) bus_cycle(1'b1, 2'b10, 5'(16 + (r << 2)), 32'h0, 0);

      // R8 full-width and upper-half transfers, lower half ignored on 16-bit regs
      bus_cycle(1'b0, 2'b10, 5'h14, 32'hDEAD_BEEF, 0);
      bus_cycle(1'b1, 2'b10, 5'h14, 32'h0, 0);
      bus_cycle(1'b0, 2'b10, 5'h06, 32'hA5C3_1234, 0);
      bus_cycle(1'b1, 2'b10, 5'h06, 32'h0, 0);
      // R9 word lanes, R10 byte lanes, R11 neighbouring bits kept
      bus_cycle(1'b0, 2'b01, 5'h16, 32'h7777_0000, 0);
      bus_cycle(1'b1, 2'b10, 5'h14, 32'h0, 0);
      bus_cycle(1'b0, 2'b00, 5'h1B, 32'h5A00_0000, 0);
      bus_cycle(1'b1, 2'b10, 5'h18, 32'h0, 0);
      bus_cycle(1'b0, 2'b00, 5'h07, 32'h3C00_0000, 0);
      bus_cycle(1'b1, 2'b01, 5'h06, 32'h0, 0);
      // R6 long hold
      bus_cycle(1'b1, 2'b11, 5'h14, 32'h0, 5);

      // R2 chip select high: no response
      @(negedge clk);
      addr_i = 5'h10; rw_i = 1'b1; cs_n_i = 1'b1; as_n_i = 1'b0;
      any_ack = 1'b0;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (ack_oe_o) any_ack = 1'b1;
      end
      as_n_i = 1'b1;
      repeat (4) @(negedge clk);
      check(!any_ack, "R2 no ack without chip select", 32'(any_ack), 32'h0);

      // R12 write abandoned before data strobe
      @(negedge clk);
      addr_i = 5'h14; rw_i = 1'b0; cs_n_i = 1'b0; data_i = 32'hFFFF_FFFF; as_n_i = 1'b0;
      any_ack = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (ack_oe_o) any_ack = 1'b1;
      end
      as_n_i = 1'b1; cs_n_i = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (ack_oe_o) any_ack = 1'b1;
      end
      check(!any_ack, "R12 no ack on abandoned write", 32'(any_ack), 32'h0);
      bus_cycle(1'b1, 2'b10, 5'h14, 32'h0, 0);

      // Random traffic
      for (int n = 0; n < 300; n++) begin
         bus_cycle(1'($urandom % 2), 2'($urandom % 4), 5'($urandom % 32), $urandom, int'($urandom % 3));
      end
      for (int r = 0; r < 8; r++) bus_cycle(1'b1, 2'b10, 5'(r << 1), 32'h0, 0);
      for (int r = 0; r < 4; r++) bus_cycle(1'b1, 2'b10, 5'(16 + (r << 2)), 32'h0, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end
endmodule